// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is a full-duplex SPI master that a host drives through a small register port. Bytes written to the transmit data register queue in a transmit FIFO. While the engine is enabled and set to master, it takes the oldest queued byte and shifts it out on `mosi`, most significant bit first. At the same time it shifts eight bits in from `miso`. Each finished frame places exactly one received byte in a receive FIFO, which the host drains by reading the receive data register.

The serial clock is the block clock divided by a power of two. A three-bit exponent in the configuration register sets the division. The clock polarity and phase bits select one of the four usual SPI modes. Four active-low chip-select lines come from a one-cold field in the configuration register. In manual mode they follow that field for as long as software leaves it alone, so a command and its data go out back to back inside one select window. In automatic mode the selected line is low only while a frame is shifting.

The FIFO edges use valid/ready signalling. `tx_ready` high means a write to the transmit data register will be accepted. A write made while it is low is discarded. `rx_valid` high means a read of the receive data register returns a byte and removes it. A read made while it is low returns zero and removes nothing. The engine never stalls on a full receive FIFO: a byte that finishes while the receive FIFO is full is lost.

Top module: `spi_master_engine`

## Requirements
- R1: After reset `sclk` is 0, `mosi` is 0, `cs_n` is 4'hF, `tx_ready` is 1 and `rx_valid` is 0. The configuration register (offset 0x00) reads 0x0000_3C00, and the enable register (offset 0x14) reads 0.
- R2: Offset 0x00 stores these bits: bit 0 master, bit 1 clock polarity, bit 2 clock phase, bits 5:3 divider exponent, bits 13:10 chip-select field and bit 14 manual select. Bits 9:6 and 31:15 read back as 0.
- R3: A frame starts on its own only when the enable bit (offset 0x14, bit 0) is 1, the master bit is 1 and the transmit FIFO holds a byte. With the master bit at 0, `sclk` does not move and no byte is received.
- R4: Each frame is 8 bits, most significant bit first. It delivers exactly one byte to the receive FIFO: the eight `miso` bits sampled during that frame.
- R5: Between frames `sclk` rests at the polarity bit. With phase 0, data is sampled on the leading edge and changed on the trailing edge. With phase 1, data is changed on the leading edge and sampled on the trailing edge.
- R6: Each `sclk` half-period lasts 2^x clock cycles, where x is the divider exponent. An exponent of 0 behaves as 1.
- R7: When the manual-select bit is 1 and the block is enabled, `cs_n` equals the chip-select field at all times, including between bytes and after the queue empties. It stays so until software writes a new field; writing 4'hF deselects all devices.
- R8: When the manual-select bit is 0, `cs_n` is 4'hF except while a frame is shifting. During a frame it equals the chip-select field.
- R9: Writing 0 to the enable bit abandons any frame in progress. On the next cycle `sclk` returns to the polarity level and `cs_n` goes to 4'hF, and the abandoned frame delivers no received byte.
- R10: A write to offset 0x1C pushes bits 7:0 into the transmit FIFO, which holds FIFO_DEPTH bytes. `tx_ready` is 0 when the FIFO is full, and a write made then is discarded.
- R11: A read of offset 0x20 returns the oldest received byte in bits 7:0 on `reg_rdata` one cycle later and removes it. When `rx_valid` is 0 the read returns 0 and removes nothing.
- R12: A frame that completes while the receive FIFO is full loses its received byte. The bytes already stored are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| tx_ready | output | 1 | Transmit FIFO can accept a byte |
| rx_valid | output | 1 | Receive FIFO holds a byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
A wrong edge index or divider count shows on the pins within one frame. Possible symptoms are a ninth `sclk` pulse, a short or long half-period, or `mosi` changing on a sampling edge. A slave model that captures `mosi` on the mode's sampling edge reports these as corrupted bytes as soon as that frame ends. A shift register in the wrong state, or a wrong bit order, appears as a mismatching received byte at the next read of the receive data register. A FIFO pointer or count error appears as a byte out of order, a lost byte or a wrong `tx_ready`/`rx_valid` level when the queue next crosses full or empty.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int FRAME_W = 8;
  localparam int DIV_W   = 3;
  localparam int CS_W    = 4;

  localparam logic [5:0] OFF_CFG = 6'h00;
  localparam logic [5:0] OFF_EN  = 6'h14;
  localparam logic [5:0] OFF_TXD = 6'h1C;
  localparam logic [5:0] OFF_RXD = 6'h20;

  typedef struct packed {
    logic             man_sel;
    logic [CS_W-1:0]  sel_n;
    logic [3:0]       rsvd;
    logic [DIV_W-1:0] div_exp;
    logic             cpha;
    logic             cpol;
    logic             master;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{man_sel: 1'b0, sel_n: '1, rsvd: '0,
                                 div_exp: '0, cpha: 1'b0, cpol: 1'b0,
                                 master: 1'b0};
endpackage

// File: rtl/spi_eng_fifo.sv
module spi_eng_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
  import spi_eng_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [DIV_W-1:0]   div_exp,
  input  logic               tx_avail,
  input  logic [FRAME_W-1:0] tx_byte,
  input  logic               miso,
  output logic               take,
  output logic               busy,
  output logic               sclk,
  output logic               mosi,
  output logic               rx_push,
  output logic [FRAME_W-1:0] rx_byte
);
  localparam int CNT_W  = (1 << DIV_W) - 1;
  localparam int EDGES  = 2 * FRAME_W;
  localparam int EDGE_W = $clog2(EDGES);

  logic [DIV_W-1:0]   eff_exp;
  logic [CNT_W:0]     half_len;
  logic [CNT_W-1:0]   half_m1, div_cnt;
  logic [EDGE_W-1:0]  edge_idx;
  logic               tgl, tick, leading, last;
  logic [FRAME_W-1:0] tx_sh, rx_sh;

  assign eff_exp  = (div_exp == '0) ? DIV_W'(1) : div_exp;
  assign half_len = (CNT_W + 1)'(1) << eff_exp;
  assign half_m1  = CNT_W'(half_len - 1'b1);
  assign tick     = busy && (div_cnt == half_m1);
  assign leading  = ~edge_idx[0];
  assign last     = (edge_idx == EDGE_W'(EDGES - 1));

  assign take    = run && !busy && tx_avail;
  assign rx_push = run && tick && last;
  assign rx_byte = cpha ? {rx_sh[FRAME_W-2:0], miso} : rx_sh;
  assign sclk    = cpol ^ tgl;
  assign mosi    = tx_sh[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      div_cnt  <= '0;
      edge_idx <= '0;
      tgl      <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else if (!run) begin
      busy     <= 1'b0;
      div_cnt  <= '0;
      edge_idx <= '0;
      tgl      <= 1'b0;
    end else if (take) begin
      busy     <= 1'b1;
      div_cnt  <= '0;
      edge_idx <= '0;
      tgl      <= 1'b0;
      tx_sh    <= tx_byte;
    end else if (tick) begin
      div_cnt  <= '0;
      tgl      <= ~tgl;
      edge_idx <= edge_idx + 1'b1;
      if (leading) begin
        if (!cpha)               rx_sh <= {rx_sh[FRAME_W-2:0], miso};
        else if (edge_idx != '0) tx_sh <= tx_sh << 1;
      end else begin
        if (cpha)       rx_sh <= {rx_sh[FRAME_W-2:0], miso};
        else if (!last) tx_sh <= tx_sh << 1;
        if (last)       busy  <= 1'b0;
      end
    end else if (busy) begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_eng_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [5:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            tx_ready,
  output logic            rx_valid,
  output logic            sclk,
  output logic            mosi,
  input  logic            miso,
  output logic [CS_W-1:0] cs_n
);
  localparam int CFG_W = $bits(cfg_t);

  cfg_t               cfg_q;
  logic               en_q, run;
  logic               tx_push, tx_take, tx_full, tx_empty;
  logic               rx_pop, rx_push, rx_full, rx_empty;
  logic [FRAME_W-1:0] tx_head, rx_head, rx_byte;
  logic               sh_busy;
  logic [31-CFG_W:0]  wdata_unused;

  assign wdata_unused = reg_wdata[31:CFG_W];
  assign run      = en_q && cfg_q.master;
  assign tx_push  = reg_wr && (reg_addr == OFF_TXD);
  assign rx_pop   = reg_rd && (reg_addr == OFF_RXD);
  assign tx_ready = !tx_full;
  assign rx_valid = !rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= CFG_RESET;
      en_q      <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == OFF_CFG) begin
        cfg_q      <= cfg_t'(reg_wdata[CFG_W-1:0]);
        cfg_q.rsvd <= '0;
      end
      if (reg_wr && reg_addr == OFF_EN) en_q <= reg_wdata[0];
      if (reg_rd) begin
        case (reg_addr)
          OFF_CFG: reg_rdata <= {{(32-CFG_W){1'b0}}, cfg_q};
          OFF_EN:  reg_rdata <= {31'b0, en_q};
          OFF_RXD: reg_rdata <= rx_empty ? '0 : {{(32-FRAME_W){1'b0}}, rx_head};
          default: reg_rdata <= '0;
        endcase
      end
    end
  end

  always_comb begin
    if (!en_q)                      cs_n = '1;
    else if (cfg_q.man_sel)         cs_n = cfg_q.sel_n;
    else if (sh_busy)               cs_n = cfg_q.sel_n;
    else                            cs_n = '1;
  end

  spi_eng_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .din(reg_wdata[FRAME_W-1:0]),
    .pop(tx_take), .dout(tx_head),
    .full(tx_full), .empty(tx_empty)
  );

  spi_eng_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_head),
    .full(rx_full), .empty(rx_empty)
  );

  spi_eng_shifter u_shifter (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cpol(cfg_q.cpol), .cpha(cfg_q.cpha), .div_exp(cfg_q.div_exp),
    .tx_avail(!tx_empty), .tx_byte(tx_head), .miso(miso),
    .take(tx_take), .busy(sh_busy), .sclk(sclk), .mosi(mosi),
    .rx_push(rx_push), .rx_byte(rx_byte)
  );
endmodule

// File: rtl/spi_eng_checker.sv
module spi_eng_checker
  import spi_eng_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            run,
  input logic            cpol,
  input logic            cpha,
  input logic            busy,
  input logic            take,
  input logic            rx_push,
  input logic            sclk,
  input logic            mosi,
  input logic [CS_W-1:0] cs_n
);
  logic       past_ok, sclk_d;
  logic [5:0] tog_n;
  logic [1:0] outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      sclk_d  <= 1'b0;
      tog_n   <= '0;
      outst   <= '0;
    end else begin
      past_ok <= 1'b1;
      sclk_d  <= sclk;
      if (take)                tog_n <= '0;
      else if (sclk != sclk_d) tog_n <= tog_n + 1'b1;
      if (take)                          outst <= outst + 1'b1;
      else if (rx_push || (busy && !run)) outst <= outst - 1'b1;
    end
  end

  assert_cs_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> cs_n == '1);

  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !busy && !$past(busy) && $stable(cpol)) |-> $stable(sclk));

  assert_mosi_steady_on_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && busy && $past(busy) && sclk != $past(sclk) && ((sclk != cpol) ^ cpha))
      |-> $stable(mosi));

  assert_sixteen_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $fell(busy) && run) |-> (tog_n + 6'(sclk != sclk_d)) == 6'd16);

  assert_one_frame_in_flight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= 2'd1);

  assert_push_matches_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> outst == 2'd1);
endmodule

bind spi_master_engine spi_eng_checker u_spi_eng_checker (
  .clk(clk), .rst_n(rst_n), .en(en_q), .run(run),
  .cpol(cfg_q.cpol), .cpha(cfg_q.cpha), .busy(sh_busy),
  .take(tx_take), .rx_push(rx_push), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/test_spi_master_engine.sv
`timescale 1ns/1ps
module test_spi_master_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_ready, rx_valid, sclk, mosi, miso;
  logic [3:0]  cs_n;

  always #4 clk = ~clk;

  spi_master_engine #(.FIFO_DEPTH(16)) i_spi_master_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  int checks = 0, errors = 0;

  // slave model: samples mosi on the mode's sampling edge, drives miso on the other
  logic       sl_on = 1'b0, sl_cpol = 1'b0, sl_cpha = 1'b0;
  logic [7:0] sl_in = '0, sl_out = '0;
  int         sl_cnt = 0, sl_idx = 0, cap_n = 0, sclk_edges = 0;
  logic [7:0] cap [0:31];

  assign miso = sl_out[7];

  function automatic logic [7:0] resp_byte(int i);
    return 8'h3C ^ 8'(i * 29 + 7);
  endfunction

  always @(sclk) begin
    if (rst_n) sclk_edges++;
    if (sl_on) begin
      if ((sclk == 1'b1) == (sl_cpol == sl_cpha)) begin
        sl_in = {sl_in[6:0], mosi};
        sl_cnt++;
        if (sl_cnt == 8) begin
          if (cap_n < 32) cap[cap_n] = sl_in;
          cap_n++;
          sl_cnt = 0;
        end
      end else begin
        if (sl_cnt == 0) begin
          sl_out = resp_byte(sl_idx);
          sl_idx++;
        end else sl_out = sl_out << 1;
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] cfgw(logic man, logic [3:0] sel, logic [2:0] dx,
                                       logic cpha, logic cpol, logic mst);
    return {17'b0, man, sel, 4'b0, dx, cpha, cpol, mst};
  endfunction

  task automatic slave_reset(logic cpol, logic cpha);
    sl_on = 1'b0; sl_cpol = cpol; sl_cpha = cpha;
    sl_cnt = 0; cap_n = 0; sl_in = '0;
    if (!cpha) begin sl_out = resp_byte(0); sl_idx = 1; end
    else begin sl_out = '0; sl_idx = 0; end
    sl_on = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 sclk", 32'(sclk), 0);
    check("R1 mosi", 32'(mosi), 0);
    check("R1 cs_n", 32'(cs_n), 32'hF);
    check("R1 tx_ready", 32'(tx_ready), 1);
    check("R1 rx_valid", 32'(rx_valid), 0);
    rd(6'h00, d); check("R1 cfg reset", d, 32'h3C00);
    rd(6'h14, d); check("R1 enable reset", d, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, d); check("R2 cfg readback", d, 32'h7C3F);
    check("R5 idle at cpol=1", 32'(sclk), 1);
    wr(6'h00, 32'h3C00);
    rd(6'h00, d); check("R2 cfg restore", d, 32'h3C00);
  endtask

  task automatic t_mode(int m);
    logic [31:0] d;
    logic [7:0]  tx [0:2];
    logic cpol = m[1], cpha = m[0];
    tx[0] = 8'hC3 ^ 8'(m); tx[1] = 8'h5A ^ 8'(m * 3); tx[2] = 8'h81 ^ 8'(m * 5);
    wr(6'h00, cfgw(1'b1, 4'hB, 3'd1, cpha, cpol, 1'b1));
    slave_reset(cpol, cpha);
    check($sformatf("R5 idle level mode%0d", m), 32'(sclk), 32'(cpol));
    for (int k = 0; k < 3; k++) wr(6'h1C, {24'h0, tx[k]});
    wr(6'h14, 1);
    idle(20);
    check($sformatf("R7 cs during frame mode%0d", m), 32'(cs_n), 32'hB);
    idle(120);
    check($sformatf("R7 cs held after queue mode%0d", m), 32'(cs_n), 32'hB);
    check($sformatf("R5 idle after frames mode%0d", m), 32'(sclk), 32'(cpol));
    check($sformatf("R4 frame count mode%0d", m), 32'(cap_n), 3);
    for (int k = 0; k < 3; k++)
      check($sformatf("R5 mosi byte%0d mode%0d", k, m), 32'(cap[k]), 32'(tx[k]));
    for (int k = 0; k < 3; k++) begin
      rd(6'h20, d);
      check($sformatf("R4 miso byte%0d mode%0d", k, m), d, 32'(resp_byte(k)));
    end
    wr(6'h00, cfgw(1'b1, 4'hF, 3'd1, cpha, cpol, 1'b1));
    check($sformatf("R7 deselect mode%0d", m), 32'(cs_n), 32'hF);
    wr(6'h14, 0);
    sl_on = 1'b0;
  endtask

  task automatic t_div(logic [2:0] dx, int half);
    logic [31:0] d;
    int n;
    sl_on = 1'b0;
    wr(6'h00, cfgw(1'b0, 4'hE, dx, 1'b0, 1'b0, 1'b1));
    wr(6'h14, 1);
    idle(2);
    check($sformatf("R8 cs idle div%0d", dx), 32'(cs_n), 32'hF);
    wr(6'h1C, 32'h55);
    wait (sclk == 1'b1);
    check($sformatf("R8 cs active div%0d", dx), 32'(cs_n), 32'hE);
    n = 0;
    @(negedge clk);
    while (sclk == 1'b1) begin n++; @(negedge clk); end
    check($sformatf("R6 half period exp%0d", dx), n, half);
    idle(16 * half + 10);
    check($sformatf("R8 cs after frame div%0d", dx), 32'(cs_n), 32'hF);
    rd(6'h20, d);
    wr(6'h14, 0);
  endtask

  task automatic t_master_off();
    logic [31:0] d;
    int e0;
    sl_on = 1'b0;
    wr(6'h00, cfgw(1'b1, 4'hE, 3'd1, 1'b0, 1'b0, 1'b0));
    wr(6'h14, 1);
    e0 = sclk_edges;
    wr(6'h1C, 32'h3A);
    idle(80);
    check("R3 no sclk without master", sclk_edges, e0);
    check("R3 no rx without master", 32'(rx_valid), 0);
    wr(6'h00, cfgw(1'b1, 4'hE, 3'd1, 1'b0, 1'b0, 1'b1));
    idle(50);
    check("R3 frame after master set", 32'(rx_valid), 1);
    rd(6'h20, d);
    wr(6'h14, 0);
  endtask

  task automatic t_abort();
    int e0;
    sl_on = 1'b0;
    wr(6'h00, cfgw(1'b1, 4'hE, 3'd3, 1'b0, 1'b1, 1'b1));
    wr(6'h1C, 32'hA7);
    e0 = sclk_edges;
    wr(6'h14, 1);
    idle(40);
    check("R9 frame running", 32'(sclk_edges != e0), 1);
    wr(6'h14, 0);
    idle(1);
    check("R9 sclk to cpol", 32'(sclk), 1);
    check("R9 cs released", 32'(cs_n), 32'hF);
    e0 = sclk_edges;
    idle(200);
    check("R9 stays idle", sclk_edges, e0);
    check("R9 no rx byte", 32'(rx_valid), 0);
    wr(6'h00, 32'h3C00);
  endtask

  task automatic t_fill();
    logic [31:0] d;
    int bad = 0;
    wr(6'h00, cfgw(1'b1, 4'hE, 3'd1, 1'b0, 1'b0, 1'b1));
    slave_reset(1'b0, 1'b0);
    for (int k = 0; k < 16; k++) wr(6'h1C, 32'(8'(k * 17 + 3)));
    check("R10 tx full", 32'(tx_ready), 0);
    wr(6'h1C, 32'hEE);
    wr(6'h14, 1);
    idle(16 * 34 + 30);
    check("R10 frames sent", 32'(cap_n), 16);
    check("R10 last byte kept", 32'(cap[15]), 32'(8'(15 * 17 + 3)));
    check("R10 tx ready again", 32'(tx_ready), 1);
    wr(6'h1C, 32'h77);
    idle(60);
    check("R12 extra frame ran", 32'(cap_n), 17);
    for (int k = 0; k < 16; k++) begin
      rd(6'h20, d);
      if (d !== 32'(resp_byte(k))) bad++;
    end
    check("R12 stored bytes intact", bad, 0);
    check("R11 rx empty", 32'(rx_valid), 0);
    rd(6'h20, d);
    check("R11 empty read zero", d, 0);
    wr(6'h14, 0);
    sl_on = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_cfg();
    for (int m = 0; m < 4; m++) t_mode(m);
    t_div(3'd3, 8);
    t_div(3'd0, 2);
    t_master_off();
    t_abort();
    t_fill();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule